// File: doc/BRIEF.md
# Card Initialization Clock Sequencer

This block runs the start-up sequence that an SD/MMC card needs once its supply is stable. It watches the power-mode code that the host requests. When the code changes into the powered-on value, it raises an init-mode control. It then writes a dummy command word of all zeros and waits for the command path to report command-complete. While init mode is held, the block itself drives a free-running card clock. It does not accept completion until at least a parameterised number of card clock rising edges has gone out, 74 by default.

On success, init mode is dropped first. In the following cycle a status-clear strobe writes a one to bit 0 of the status word, which acknowledges command-complete. The wait is bounded by a cycle counter, sized for 1 ms at the module clock. If the counter runs out, the block flags a timeout error, leaves init mode asserted and returns to idle without acknowledging anything. The host interrupt stays masked from the cycle the sequence starts until it ends, on either outcome.

Top module: `card_init_seq`

## Requirements
- R1: A sequence starts in the cycle after `mode_set` only if `mode_code` is the power-on code 2 and differs from the stored code. The codes are 0 for off, 1 for ramping and 3 for reserved. After reset the stored code is 0.
- R2: `irq_mask` is high in exactly the cycles in which `busy` is high, from the first cycle of the sequence to its last.
- R3: The dummy command strobe `cmd_wr` is high for exactly one cycle per sequence, with `init_mode` already high and `cmd_word` equal to zero.
- R4: Completion is taken only once `cmd_done` (status bit 0) is high and at least MIN_CLKS card clock rising edges have gone out since the dummy command.
- R5: `card_clk` toggles every DIV_HALF module clocks while `init_mode` is high. It is low in the cycle after `init_mode` is low.
- R6: If no completion is seen within TIMEOUT_CYC cycles after the dummy command, `tmo_err` rises and `busy` falls TIMEOUT_CYC+1 cycles after the `cmd_wr` cycle. `init_mode` stays high and no status clear is issued.
- R7: On success, `init_mode` falls one cycle before a single `stat_clr` pulse. That pulse carries `stat_clr_data` with only bit 0 set.
- R8: `tmo_err` holds until the next sequence starts, and is cleared at that start.
- R9: Every `mode_set` updates the stored code, even while a sequence runs. A start condition seen while busy is ignored.
- R10: After reset, `busy`, `irq_mask`, `init_mode`, `cmd_wr`, `stat_clr`, `tmo_err` and `card_clk` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_set | input | 1 | Strobe: apply `mode_code` |
| mode_code | input | 2 | Requested power mode (0 off, 1 ramp, 2 on) |
| cmd_done | input | 1 | Command-complete status bit 0 from the command path |
| init_mode | output | 1 | Init-mode control to the command path |
| cmd_wr | output | 1 | Dummy command write strobe |
| cmd_word | output | CMD_W | Command word written with `cmd_wr` (all zero) |
| stat_clr | output | 1 | Status write strobe acknowledging completion |
| stat_clr_data | output | STAT_W | Write-one-to-clear data for the status word |
| irq_mask | output | 1 | Masks the host interrupt while high |
| busy | output | 1 | Sequence in progress |
| tmo_err | output | 1 | Last sequence timed out |
| card_clk | output | 1 | Card clock driven during init mode |

## Verification
The bench builds the block with MIN_CLKS=6, DIV_HALF=2 and TIMEOUT_CYC=60. With these values a full sequence takes a few dozen cycles, and the exact timeout length can be counted in the bench. It also allows every one of the 16 pairs of stored and requested power codes to be swept, each from a fresh reset. Completion is tried with the status bit present at once, with it arriving after the clock minimum is met, and with it never arriving. A request for the powered-off code made mid-sequence is used to confirm that the stored code still follows.

// File: rtl/card_init_pkg.sv
// Package: shared codes for the card initialization sequencer.
// Assumes a two-bit power-mode code from the host side.
package card_init_pkg;
    localparam logic [1:0] PWR_OFF  = 2'd0;
    localparam logic [1:0] PWR_RAMP = 2'd1;
    localparam logic [1:0] PWR_ON   = 2'd2;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ARM,
        S_ISSUE,
        S_WAIT,
        S_DROP,
        S_ACK
    } seq_state_e;
endpackage

// File: rtl/init_clk_gen.sv
// Module: init_clk_gen
// Drives a divided card clock while run is high and counts its rising
// edges since the last restart, saturating at MIN_CLKS.
// Assumes DIV_HALF >= 1 and MIN_CLKS >= 1.
module init_clk_gen #(
    parameter int DIV_HALF = 2,
    parameter int MIN_CLKS = 74
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic card_clk,
    output logic enough
);
    localparam int DW = $clog2(DIV_HALF + 1);
    localparam int CW = $clog2(MIN_CLKS + 1);

    logic [DW-1:0] div_q;
    logic [CW-1:0] cnt_q;
    logic          clk_q;
    logic          wrap;

    assign wrap     = (div_q == DW'(DIV_HALF - 1));
    assign card_clk = clk_q;
    assign enough   = (cnt_q == CW'(MIN_CLKS));

    // Divider: toggles the card clock on every wrap, parks low when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            div_q <= '0;
            clk_q <= 1'b0;
        end else if (wrap) begin
            div_q <= '0;
            clk_q <= ~clk_q;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    // Edge counter: counts low-to-high toggles, saturates at the minimum.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt_q <= '0;
        end else if (run && wrap && !clk_q && !enough) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_CLK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !card_clk); // R5
endmodule

// File: rtl/wait_timer.sv
// Module: wait_timer
// Counts module cycles while run is high; expired flags the last cycle
// of a TIMEOUT_CYC-cycle window that begins after load.
// Assumes TIMEOUT_CYC >= 2.
module wait_timer #(
    parameter int TIMEOUT_CYC = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expired
);
    localparam int TW = $clog2(TIMEOUT_CYC + 1);

    logic [TW-1:0] cnt_q;

    assign expired = run && (cnt_q == TW'(TIMEOUT_CYC - 1));

    // Cycle counter: cleared on load, advances while the wait is active.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            cnt_q <= '0;
        end else if (run && !expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= TW'(TIMEOUT_CYC - 1)); // R6
endmodule

// File: rtl/card_init_seq.sv
// Module: card_init_seq (top)
// Detects a power-mode change into the on state, then sets init mode,
// writes a zero command, waits for completion (bounded), drops init mode
// and acknowledges the completion status. Host interrupt masked meanwhile.
// Assumes cmd_done is synchronous to clk and stays high until cleared.
module card_init_seq #(
    parameter int CMD_W       = 32,
    parameter int STAT_W      = 32,
    parameter int MIN_CLKS    = 74,
    parameter int DIV_HALF    = 2,
    parameter int TIMEOUT_CYC = 100000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_set,
    input  logic [1:0]        mode_code,
    input  logic              cmd_done,
    output logic              init_mode,
    output logic              cmd_wr,
    output logic [CMD_W-1:0]  cmd_word,
    output logic              stat_clr,
    output logic [STAT_W-1:0] stat_clr_data,
    output logic              irq_mask,
    output logic              busy,
    output logic              tmo_err,
    output logic              card_clk
);
    import card_init_pkg::*;

    seq_state_e state_q, state_d;
    logic [1:0] stored_q;
    logic       init_q, mask_q, tmo_q;
    logic       start, enough, expired, done_ok, give_up;

    assign start   = mode_set && (mode_code == PWR_ON) &&
                     (mode_code != stored_q) && (state_q == S_IDLE);
    assign done_ok = (state_q == S_WAIT) && cmd_done && enough;
    assign give_up = (state_q == S_WAIT) && expired && !done_ok;

    init_clk_gen #(.DIV_HALF(DIV_HALF), .MIN_CLKS(MIN_CLKS)) u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (init_q),
        .restart  (state_q == S_ISSUE),
        .card_clk (card_clk),
        .enough   (enough)
    );

    wait_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (state_q == S_ISSUE),
        .run     (state_q == S_WAIT),
        .expired (expired)
    );

    // Next-state logic for the sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start) state_d = S_ARM;
            S_ARM:   state_d = S_ISSUE;
            S_ISSUE: state_d = S_WAIT;
            S_WAIT:  if (done_ok) state_d = S_DROP;
                     else if (give_up) state_d = S_IDLE;
            S_DROP:  state_d = S_ACK;
            S_ACK:   state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Stored power mode follows every request, busy or not.
    always_ff @(posedge clk) begin
        if (!rst_n)        stored_q <= PWR_OFF;
        else if (mode_set) stored_q <= mode_code;
    end

    // Init-mode control: set before the command, cleared only on success.
    always_ff @(posedge clk) begin
        if (!rst_n)                  init_q <= 1'b0;
        else if (state_q == S_ARM)   init_q <= 1'b1;
        else if (state_q == S_DROP)  init_q <= 1'b0;
    end

    // Interrupt mask: raised at start, released when the sequence leaves.
    always_ff @(posedge clk) begin
        if (!rst_n)                              mask_q <= 1'b0;
        else if (start)                          mask_q <= 1'b1;
        else if (state_q == S_ACK || give_up)    mask_q <= 1'b0;
    end

    // Timeout flag: set on give-up, cleared by the next start.
    always_ff @(posedge clk) begin
        if (!rst_n)       tmo_q <= 1'b0;
        else if (start)   tmo_q <= 1'b0;
        else if (give_up) tmo_q <= 1'b1;
    end

    assign busy          = (state_q != S_IDLE);
    assign init_mode     = init_q;
    assign irq_mask      = mask_q;
    assign tmo_err       = tmo_q;
    assign cmd_wr        = (state_q == S_ISSUE);
    assign cmd_word      = '0;
    assign stat_clr      = (state_q == S_ACK);
    assign stat_clr_data = STAT_W'(1);

    AST_MASK_COVERS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> irq_mask); // R2
    AST_CMD_IN_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |-> init_mode); // R3
    AST_CLR_AFTER_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        stat_clr |-> (!init_mode && $past(init_mode))); // R7
    AST_TMO_KEEPS_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_err) |-> (init_mode && !busy)); // R6
    AST_DROP_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WAIT && state_d == S_DROP) |-> (cmd_done && enough)); // R4
endmodule

// File: tb/sim_card_init_seq.sv
// Bench for card_init_seq: sweeps every stored/requested power-code pair,
// and runs success, late-completion, timeout and mid-run update cases.
module sim_card_init_seq;
    localparam int CMD_W = 16, STAT_W = 8, MIN = 6, DIVH = 2, TMO = 60;

    logic clk = 1'b0, rst_n = 1'b0, mode_set = 1'b0, cmd_done = 1'b0;
    logic [1:0] mode_code = 2'd0;
    logic init_mode, cmd_wr, stat_clr, irq_mask, busy, tmo_err, card_clk;
    logic [CMD_W-1:0]  cmd_word;
    logic [STAT_W-1:0] stat_clr_data;
    int total = 0, bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    card_init_seq #(.CMD_W(CMD_W), .STAT_W(STAT_W), .MIN_CLKS(MIN),
                    .DIV_HALF(DIVH), .TIMEOUT_CYC(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_set(mode_set), .mode_code(mode_code),
        .cmd_done(cmd_done), .init_mode(init_mode), .cmd_wr(cmd_wr),
        .cmd_word(cmd_word), .stat_clr(stat_clr), .stat_clr_data(stat_clr_data),
        .irq_mask(irq_mask), .busy(busy), .tmo_err(tmo_err), .card_clk(card_clk));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; mode_set = 1'b0; cmd_done = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Applies a power-mode request; returns at the negedge after the edge.
    task automatic set_mode(input logic [1:0] code);
        mode_set = 1'b1; mode_code = code;
        @(posedge clk); @(negedge clk);
        mode_set = 1'b0;
    endtask

    // Follows one sequence from its first busy cycle to idle.
    task automatic observe(input int done_at, input bit exp_tmo, input bit mid_off);
        int cyc = 0, rises = 0, wr_n = 0, clr_n = 0, wr_cyc = -1, clr_cyc = -1;
        bit prev_init = init_mode, prev_clk = card_clk;
        bit ok_mask = 1, ok_wr = 1, ok_clr = 1, ok_clk = 1, late = 0;
        while (busy && cyc < 5000) begin
            cmd_done = (cyc >= done_at);
            if (irq_mask !== busy) ok_mask = 0;
            if (cmd_wr) begin
                wr_n++; wr_cyc = cyc;
                if (!init_mode || cmd_word != 0) ok_wr = 0;
            end
            if (!prev_init && card_clk) ok_clk = 0;
            if (card_clk && !prev_clk && wr_cyc >= 0) rises++;
            if (stat_clr) begin
                clr_n++; clr_cyc = cyc;
                if (init_mode || !prev_init || stat_clr_data != STAT_W'(1)) ok_clr = 0;
                if (rises >= MIN && cyc > done_at) late = 1;
            end
            prev_init = init_mode; prev_clk = card_clk;
            mode_set = (mid_off && cyc == 8);
            mode_code = mid_off ? 2'd0 : mode_code;
            @(posedge clk); @(negedge clk);
            mode_set = 1'b0;
            cyc++;
        end
        cmd_done = 1'b0;
        check(ok_mask, "R2 irq_mask tracks busy", ok_mask, 1);
        check(ok_wr && wr_n == 1, "R3 one zero command in init mode", wr_n, 1);
        check(ok_clk, "R5 card clock only in init mode", ok_clk, 1);
        if (exp_tmo) begin
            check(cyc - wr_cyc == TMO + 1, "R6 timeout length", cyc - wr_cyc, TMO + 1);
            check(tmo_err && init_mode && clr_n == 0, "R6 timeout leaves init set",
                  {tmo_err, init_mode, 1'b0} | clr_n, 6);
        end else begin
            check(ok_clr && clr_n == 1 && !init_mode, "R7 drop then clear", clr_n, 1);
            check(late, "R4 completion after status and clocks", clr_cyc, done_at);
            check(!tmo_err, "R8 no error on success", tmo_err, 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        @(negedge clk);
        check({busy, irq_mask, init_mode, cmd_wr, stat_clr, tmo_err, card_clk} == 0,
              "R10 reset state",
              {busy, irq_mask, init_mode, cmd_wr, stat_clr, tmo_err, card_clk}, 0);

        // R1 sweep over every stored/requested code pair.
        for (int f = 0; f < 4; f++) begin
            for (int t = 0; t < 4; t++) begin
                bit exp;
                do_reset();
                @(negedge clk);
                if (f != 0) begin
                    set_mode(2'(f));
                    if (busy) observe(0, 1'b0, 1'b0);
                end
                set_mode(2'(t));
                exp = (t == 2) && (t != f);
                check(busy == exp, $sformatf("R1 start from %0d to %0d", f, t), busy, exp);
                if (busy) observe(0, 1'b0, 1'b0);
            end
        end

        // R4: status arrives well after the clock minimum is met.
        do_reset(); @(negedge clk);
        set_mode(2'd2);
        observe(40, 1'b0, 1'b0);

        // R6: status never arrives.
        do_reset(); @(negedge clk);
        set_mode(2'd2);
        observe(100000, 1'b1, 1'b0);
        repeat (4) @(negedge clk);
        check(tmo_err && !busy && !irq_mask, "R8 error held while idle", tmo_err, 1);
        // R8: next start clears the error.
        set_mode(2'd0);
        set_mode(2'd2);
        check(busy && !tmo_err, "R8 error cleared at start", tmo_err, 0);
        observe(0, 1'b0, 1'b0);

        // R9: off request during a run updates the stored code only.
        do_reset(); @(negedge clk);
        set_mode(2'd2);
        observe(0, 1'b0, 1'b1);
        set_mode(2'd2);
        check(busy, "R9 stored code followed mid-run request", busy, 1);
        observe(0, 1'b0, 1'b0);
        // R9: repeat on request while already on does nothing.
        set_mode(2'd2);
        check(!busy, "R9 same code no restart", busy, 0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule